// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers 32 interrupt sources into one request line for a parent interrupt controller. Software reaches it through a small word-addressed register port. A compile-time parameter picks one of two variants. In the latched variant, a rising edge on a source sets a sticky pending bit. Software can also force a pending bit, and it drops one by writing a 1 to the acknowledge register. In the level variant there is no pending storage: the status register shows the present level of each source, and there is no acknowledge or force register.

Each source also has a mask bit, and 1 means the source is disabled. Software never writes the mask as a whole word. It writes ones to a mask-on register to disable sources, and ones to a mask-off register to enable them. The current mask can be read back. The combined output is high whenever some source is pending and not masked. Software finds the cause by reading the status register and scanning it.

Top module: `irq_aggregator`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), every mask bit is 1, every latched pending bit is 0, irq_out is 0 and bus_rdata is 0.
- R2: In the latched variant (LATCHED=1), a 0-to-1 change on irq_in[i] between two clock edges sets pending bit i. A source that stays high does not set the bit again after it has been acknowledged. Status is read at byte offset 0x00.
- R3: In the latched variant, writing word W to offset 0x08 clears the pending bits where W is 1. Bits where W is 0 are unchanged.
- R4: In the latched variant, if a rising edge on source i and an acknowledge write with bit i set happen in the same cycle, pending bit i ends up 1.
- R5: In the latched variant, writing word W to offset 0x04 sets the pending bits where W is 1.
- R6: Writing ones to the mask-on register sets those mask bits, and writing ones to the mask-off register clears them. Zero bits change nothing. The mask-on register is at 0x10 and mask-off at 0x14 in the latched variant; they are at 0x08 and 0x0C in the level variant.
- R7: The mask-status register returns the mask, with 1 meaning disabled. It is at 0x0C in the latched variant and at 0x04 in the level variant.
- R8: irq_out is 1 exactly when (status AND NOT mask) is nonzero. It follows the current register contents with no extra cycle.
- R9: Masking a source never clears its latched pending bit, and status shows that bit whatever the mask holds.
- R10: In the level variant (LATCHED=0), status at 0x00 reads the irq_in levels present at the read edge, and irq_out follows irq_in combinationally.
- R11: Reads return zero at unmapped offsets and at write-only registers (force, acknowledge, mask-on, mask-off). Writes to unmapped offsets, to status and to mask status change nothing.
- R12: A read takes effect at the edge where bus_rd is high, and bus_rdata holds the value for the following cycle. bus_rdata is zero in any cycle that follows an edge with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NSRC | Interrupt sources, synchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, registered |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The bench drives an edge on a source in the same cycle as an acknowledge of that bit. A design where the clear wins would lose the event. It also acknowledges a source that is still held high, which catches a design that latches levels rather than edges and would keep setting the bit. Masking and then unmasking a pending source checks that masking does not discard pending state. Writes aimed at one variant's map also land in the other variant's map, where they hit read-only or unmapped offsets; a decoder that lets them through would corrupt the mask or pending state. A long random phase compares both variants against a behavioural model on every clock. That phase exposes wrong offsets, a read path with the wrong latency, and an output that lags the state by a cycle.

// File: rtl/irqagg_pkg.sv
// Shared definitions for the interrupt aggregator: register selects and
// byte offsets of both register maps.
package irqagg_pkg;

    // Register selected by the decoder for the current access.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_STATUS,
        SEL_FORCE,
        SEL_ACK,
        SEL_MASKRD,
        SEL_MASKON,
        SEL_MASKOFF
    } reg_sel_e;

    // Latched (edge) variant map.
    localparam int unsigned OFS_L_STATUS  = 32'h00;
    localparam int unsigned OFS_L_FORCE   = 32'h04;
    localparam int unsigned OFS_L_ACK     = 32'h08;
    localparam int unsigned OFS_L_MASKRD  = 32'h0C;
    localparam int unsigned OFS_L_MASKON  = 32'h10;
    localparam int unsigned OFS_L_MASKOFF = 32'h14;

    // Level variant map.
    localparam int unsigned OFS_V_STATUS  = 32'h00;
    localparam int unsigned OFS_V_MASKRD  = 32'h04;
    localparam int unsigned OFS_V_MASKON  = 32'h08;
    localparam int unsigned OFS_V_MASKOFF = 32'h0C;

endpackage

// File: rtl/irqagg_decode.sv
// Address decoder. It maps a byte offset onto a register select for the
// variant chosen by LATCHED. Any offset that is not listed, including a
// misaligned one, gives SEL_NONE.
// Assumes: AW is wide enough to hold the largest offset (0x14).
module irqagg_decode
    import irqagg_pkg::*;
#(
    parameter int AW      = 5,
    parameter bit LATCHED = 1'b1
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);

    generate
        if (LATCHED) begin : g_latched
            // Decode the six-register map of the edge variant.
            always_comb begin
                case (addr)
                    AW'(OFS_L_STATUS):  sel = SEL_STATUS;
                    AW'(OFS_L_FORCE):   sel = SEL_FORCE;
                    AW'(OFS_L_ACK):     sel = SEL_ACK;
                    AW'(OFS_L_MASKRD):  sel = SEL_MASKRD;
                    AW'(OFS_L_MASKON):  sel = SEL_MASKON;
                    AW'(OFS_L_MASKOFF): sel = SEL_MASKOFF;
                    default:            sel = SEL_NONE;
                endcase
            end
        end else begin : g_level
            // Decode the four-register map of the level variant.
            always_comb begin
                case (addr)
                    AW'(OFS_V_STATUS):  sel = SEL_STATUS;
                    AW'(OFS_V_MASKRD):  sel = SEL_MASKRD;
                    AW'(OFS_V_MASKON):  sel = SEL_MASKON;
                    AW'(OFS_V_MASKOFF): sel = SEL_MASKOFF;
                    default:            sel = SEL_NONE;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/irqagg_mask.sv
// Per-source mask register (1 = disabled). Software never writes it as a
// word: ones in a mask-on write set bits, ones in a mask-off write clear
// bits. Comes out of reset all ones.
// Assumes: set_we and clr_we never arrive in the same cycle (single port).
module irqagg_mask #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] mask
);

    logic [N-1:0] mask_q;

    // Apply write-one-to-set and write-one-to-clear updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (set_we) begin
            mask_q <= mask_q | wdata;
        end else if (clr_we) begin
            mask_q <= mask_q & ~wdata;
        end
    end

    assign mask = mask_q;

    AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & $past(wdata)) == $past(wdata)));            // R6
    AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((mask & $past(wdata)) == '0));                      // R6
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask));                        // R11

endmodule

// File: rtl/irqagg_status.sv
// Source status. With LATCHED set, it keeps one sticky pending bit per
// source. A rising edge sets the bit, a force write sets it, and an
// acknowledge write clears it; an edge or force wins over an acknowledge.
// With LATCHED clear, status is the raw input level.
// Assumes: src_in is synchronous to clk; force_we and ack_we are exclusive.
module irqagg_status #(
    parameter int N       = 32,
    parameter bit LATCHED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] src_in,
    input  logic         force_we,
    input  logic         ack_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] status
);

    generate
        if (LATCHED) begin : g_latched
            logic [N-1:0] src_q;
            logic [N-1:0] pend_q;
            logic [N-1:0] rise;
            logic [N-1:0] ack_bits;
            logic [N-1:0] force_bits;

            assign rise       = src_in & ~src_q;
            assign ack_bits   = ack_we   ? wdata : '0;
            assign force_bits = force_we ? wdata : '0;

            // Remember the previous source levels for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    src_q <= '0;
                end else begin
                    src_q <= src_in;
                end
            end

            // Update pending bits: clear first, then set (set wins).
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pend_q <= '0;
                end else begin
                    pend_q <= (pend_q & ~ack_bits) | force_bits | rise;
                end
            end

            assign status = pend_q;

            AST_EDGE_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
                (rise != '0) |=> ((status & $past(rise)) == $past(rise)));  // R4
            AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                !ack_we |=> ((status & $past(status)) == $past(status)));   // R9
            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                ack_we |=> ((status & $past(wdata & ~rise)) == '0));        // R3
            AST_FORCE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
                force_we |=> ((status & $past(wdata)) == $past(wdata)));    // R5
        end else begin : g_level
            logic lvl_unused;

            assign lvl_unused = ^{clk, rst_n, force_we, ack_we, wdata};
            assign status     = src_in;
        end
    endgenerate

endmodule

// File: rtl/irq_aggregator.sv
// Top of the second-level interrupt aggregator. It decodes the register
// port, keeps the mask and status blocks, registers read data with one
// cycle of latency, and drives the combined request to the parent.
// Assumes: bus_wr and bus_rd are single-cycle strobes synchronous to clk;
// irq_in is already synchronous to clk.
module irq_aggregator
    import irqagg_pkg::*;
#(
    parameter int NSRC    = 32,
    parameter int AW      = 5,
    parameter bit LATCHED = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] irq_in,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [AW-1:0]   bus_addr,
    input  logic [NSRC-1:0] bus_wdata,
    output logic [NSRC-1:0] bus_rdata,
    output logic            irq_out
);

    reg_sel_e        sel;
    logic [NSRC-1:0] mask;
    logic [NSRC-1:0] status;
    logic [NSRC-1:0] rdata_q;

    irqagg_decode #(.AW(AW), .LATCHED(LATCHED)) u_decode (
        .addr (bus_addr),
        .sel  (sel)
    );

    irqagg_mask #(.N(NSRC)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (bus_wr && (sel == SEL_MASKON)),
        .clr_we (bus_wr && (sel == SEL_MASKOFF)),
        .wdata  (bus_wdata),
        .mask   (mask)
    );

    irqagg_status #(.N(NSRC), .LATCHED(LATCHED)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (irq_in),
        .force_we (bus_wr && (sel == SEL_FORCE)),
        .ack_we   (bus_wr && (sel == SEL_ACK)),
        .wdata    (bus_wdata),
        .status   (status)
    );

    // Capture read data for the selected readable register, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_STATUS: rdata_q <= status;
                SEL_MASKRD: rdata_q <= mask;
                default:    rdata_q <= '0;
            endcase
        end else begin
            rdata_q <= '0;
        end
    end

    assign bus_rdata = rdata_q;
    assign irq_out   = |(status & ~mask);

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));                                 // R12
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (sel == SEL_NONE)) |=> (bus_rdata == '0));           // R11
    AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((status != '0) && (mask != '1)));                  // R8

endmodule

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata_l, rdata_v;
    logic        irq_l, irq_v;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    irq_aggregator #(.NSRC(32), .AW(5), .LATCHED(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_l), .irq_out(irq_l));

    irq_aggregator #(.NSRC(32), .AW(5), .LATCHED(1'b0)) dut_lvl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(rdata_v), .irq_out(irq_v));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, updated at each rising edge.
    logic [31:0] m_pend, m_src, m_mask_l, m_mask_v, m_rd_l, m_rd_v;
    string       m_tag_l, m_tag_v;
    initial begin
        m_pend = '0; m_src = '0; m_mask_l = '1; m_mask_v = '1;
        m_rd_l = '0; m_rd_v = '0; m_tag_l = "R12"; m_tag_v = "R12";
    end

    always @(posedge clk) begin
        logic [31:0] np;
        if (!rst_n) begin
            m_pend = '0; m_src = '0; m_mask_l = '1; m_mask_v = '1;
            m_rd_l = '0; m_rd_v = '0; m_tag_l = "R1"; m_tag_v = "R1";
        end else begin
            m_rd_l = '0; m_rd_v = '0; m_tag_l = "R12"; m_tag_v = "R12";
            if (bus_rd) begin
                m_tag_l = "R11"; m_tag_v = "R11";
                if (bus_addr == 5'h00) begin m_rd_l = m_pend; m_tag_l = "R2"; end
                if (bus_addr == 5'h0C) begin m_rd_l = m_mask_l; m_tag_l = "R7"; end
                if (bus_addr == 5'h00) begin m_rd_v = irq_in; m_tag_v = "R10"; end
                if (bus_addr == 5'h04) begin m_rd_v = m_mask_v; m_tag_v = "R7"; end
            end
            np = m_pend;
            if (bus_wr && bus_addr == 5'h08) np = np & ~bus_wdata;
            if (bus_wr && bus_addr == 5'h04) np = np | bus_wdata;
            np = np | (irq_in & ~m_src);
            if (bus_wr && bus_addr == 5'h10) m_mask_l = m_mask_l | bus_wdata;
            if (bus_wr && bus_addr == 5'h14) m_mask_l = m_mask_l & ~bus_wdata;
            if (bus_wr && bus_addr == 5'h08) m_mask_v = m_mask_v | bus_wdata;
            if (bus_wr && bus_addr == 5'h0C) m_mask_v = m_mask_v & ~bus_wdata;
            m_pend = np;
            m_src  = irq_in;
        end
    end

    // Compare both variants against the model mid-cycle.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_tag_l, rdata_l, m_rd_l);
            chk(m_tag_v, rdata_v, m_rd_v);
            chk("R8", {31'd0, irq_l}, {31'd0, |(m_pend & ~m_mask_l)});
            chk("R8", {31'd0, irq_v}, {31'd0, |(irq_in & ~m_mask_v)});
        end
    end

    // Tasks start and end 1 ns after a rising edge.
    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1; rst_n = 1'b1;
        // R1 reset state
        chk("R1", {31'd0, irq_l}, 32'd0);
        chk("R1", {31'd0, irq_v}, 32'd0);
        rd(5'h0C); chk("R1", rdata_l, 32'hFFFF_FFFF);
        rd(5'h00); chk("R1", rdata_l, 32'h0);
        rd(5'h04); chk("R1", rdata_v, 32'hFFFF_FFFF);
        // R2 edge latching on sources 0 and 2
        irq_in = 32'h5; idle(1); irq_in = '0; idle(1);
        rd(5'h00); chk("R2", rdata_l, 32'h5);
        chk("R9", {31'd0, irq_l}, 32'd0);
        // R6 unmask source 0
        wr(5'h14, 32'h1);
        chk("R8", {31'd0, irq_l}, 32'd1);
        rd(5'h0C); chk("R6", rdata_l, 32'hFFFF_FFFE);
        // R3 acknowledge source 0 only
        wr(5'h08, 32'h1);
        rd(5'h00); chk("R3", rdata_l, 32'h4);
        chk("R8", {31'd0, irq_l}, 32'd0);
        // R9 masking keeps pending
        wr(5'h14, 32'h4); chk("R8", {31'd0, irq_l}, 32'd1);
        wr(5'h10, 32'h4); chk("R6", {31'd0, irq_l}, 32'd0);
        rd(5'h00); chk("R9", rdata_l, 32'h4);
        // R5 force, also read-only write on the level map
        wr(5'h04, 32'h100);
        rd(5'h00); chk("R5", rdata_l, 32'h104);
        rd(5'h04); chk("R11", rdata_v, 32'hFFFF_FFFF);
        chk("R11", rdata_l, 32'h0);
        // R4 edge and acknowledge in the same cycle
        irq_in = 32'h8; wr(5'h08, 32'h8);
        rd(5'h00); chk("R4", rdata_l, 32'h10C);
        // R2 held-high source does not re-latch
        wr(5'h08, 32'h8);
        rd(5'h00); chk("R2", rdata_l, 32'h104);
        irq_in = '0;
        // R11 unmapped offset
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18); chk("R11", rdata_l, 32'h0); chk("R11", rdata_v, 32'h0);
        rd(5'h0C); chk("R11", rdata_l, 32'hFFFF_FFFE);
        // R10 level variant
        irq_in = 32'h30; idle(1);
        rd(5'h00); chk("R10", rdata_v, 32'h30);
        wr(5'h0C, 32'h10);
        chk("R8", {31'd0, irq_v}, 32'd1);
        chk("R8", {31'd0, irq_l}, 32'd0);
        rd(5'h0C); chk("R11", rdata_l, 32'hFFFF_FFFE);
        rd(5'h04); chk("R7", rdata_v, 32'hFFFF_FFEF);
        irq_in = '0; #1;
        chk("R10", {31'd0, irq_v}, 32'd0);
        rd(5'h00); chk("R10", rdata_v, 32'h0);
        // R12 no read leaves zero
        idle(1);
        chk("R12", rdata_l, 32'h0); chk("R12", rdata_v, 32'h0);
        // Random phase against the model
        for (int i = 0; i < 3000; i++) begin
            bus_wr    = ($urandom_range(0, 2) == 0);
            bus_rd    = ($urandom_range(0, 1) == 0);
            bus_addr  = 5'(4 * $urandom_range(0, 7));
            bus_wdata = $urandom & $urandom;
            irq_in    = irq_in ^ ($urandom & $urandom & $urandom);
            @(posedge clk); #1;
        end
        bus_wr = 1'b0; bus_rd = 1'b0; idle(2);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule